// File: doc/BRIEF.md
# Parity-Line Self-Checking Reversible Gate Cascade

This block models a reversible logic network on `P` data lines as a fixed cascade of generalized Toffoli gates. Each gate may use positive or negative controls, and a gate with no controls is a plain inverter. The cascade comes in as three packed parameters: a control mask, a polarity mask and a target index for each gate. Around the network the block runs one extra check line that starts at zero. At entry every data line is folded into it. Every gate that has controls also toggles it with the same product term. At exit every data line is folded into it again. The inverters are corrected by a single final inversion when their number is odd.

A fault-free evaluation leaves the check line at zero. A single inverted line at any gate boundary leaves it at one, even when later gates spread that inversion to other data lines. The check line is never used as a control, so a fault on it cannot reach the data. For test, a fault-injection port inverts one chosen line, data or check, at one chosen boundary. The data result and the final check value are registered and appear one clock after the inputs.

Top module: `ptc_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `data_out` is all zeros and `err` is 0.
- R2: With `flt_en` low, `data_out` equals the original cascade applied to the `data_in` of the previous cycle. Gate k toggles line `TGT_IDX[8k+:8]` when every line in `CTRL_MASK[Pk+:P]` equals its bit in `POL_MASK[Pk+:P]` (1 = positive control, 0 = negative control). A gate with an empty mask always toggles.
- R3: With `flt_en` low, `err` is 0 one cycle later, for every input vector.
- R4: With `flt_en` high, `flt_line` below `P` and `flt_bnd` at most `G`, `err` is 1 one cycle later.
- R5: With `flt_en` high and `flt_line` equal to `P` (the check line), `err` is 1 one cycle later and `data_out` equals the fault-free result.
- R6: Boundary b is the point just before gate b. Boundary `G` lies after the last gate and before the closing fold, so a data fault there inverts exactly that bit of `data_out`.
- R7: When the cascade holds an odd number of control-free gates, the closing inversion of the check line keeps `err` at 0 in fault-free operation. The default cascade has one such gate.
- R8: While `flt_en` is low, the values of `flt_line` and `flt_bnd` have no effect on `data_out` or `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | P | Data line inputs |
| flt_en | input | 1 | Enables fault injection |
| flt_line | input | LINE_W | Line to invert; value P selects the check line |
| flt_bnd | input | BND_W | Boundary at which to invert, 0..G |
| data_out | output | P | Registered data line outputs |
| err | output | 1 | Registered final check-line value; 1 flags a fault |

## Verification
A wrong mask, polarity or target in a gate stage shows up as a wrong `data_out` for some input vector one clock later. A stage that fails to mirror its product term onto the check line shows up as `err` rising without any injected fault. A check-line or closing-fold defect appears as `err` staying low under some injected fault, again after one clock. Every input vector is run against every line and boundary combination, so each such defect is reached within the first sweep.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int TGT_FIELD_W = 8;
  localparam int MAX_MASK_BITS = 1024;

  // Parity of the number of gates whose control mask is empty
  function automatic logic odd_plain_inverters(input logic [MAX_MASK_BITS-1:0] masks,
                                               input int gates, input int lines);
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < gates; k++) begin
      logic any;
      any = 1'b0;
      for (int b = 0; b < lines; b++) any = any | masks[k*lines + b];
      if (!any) acc = ~acc;
    end
    return acc;
  endfunction
endpackage

// File: rtl/ptc_parity_fold.sv
module ptc_parity_fold #(
  parameter int P = 4
) (
  input  logic [P-1:0] lines_i,
  output logic         par_o
);
  always_comb begin
    par_o = 1'b0;
    for (int i = 0; i < P; i++) par_o = par_o ^ lines_i[i];
  end
endmodule

// File: rtl/ptc_fault_dec.sv
module ptc_fault_dec #(
  parameter int P      = 4,
  parameter int LINE_W = 3,
  parameter int BND_W  = 3,
  parameter int BND    = 0
) (
  input  logic              en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [BND_W-1:0]  bnd_i,
  output logic [P:0]        flip_o
);
  always_comb begin
    flip_o = '0;
    if (en_i && (int'(bnd_i) == BND)) begin
      for (int i = 0; i <= P; i++) flip_o[i] = (int'(line_i) == i);
    end
  end
endmodule

// File: rtl/ptc_gate_stage.sv
module ptc_gate_stage #(
  parameter int         P    = 4,
  parameter logic [P-1:0] CTRL = '0,
  parameter logic [P-1:0] POL  = '0,
  parameter int         TGT  = 0
) (
  input  logic [P:0] lines_i,
  input  logic [P:0] flip_i,
  output logic [P:0] lines_o
);
  localparam bit HAS_CTRL = (CTRL != '0);

  logic [P:0]   faulted;
  logic [P-1:0] satisfied;
  logic         fire;

  always_comb begin
    faulted   = lines_i ^ flip_i;
    satisfied = ~CTRL | ~(faulted[P-1:0] ^ POL);
    fire      = &satisfied;
  end

  generate
    if (HAS_CTRL) begin : g_ext
      always_comb begin
        lines_o      = faulted;
        lines_o[TGT] = faulted[TGT] ^ fire;
        lines_o[P]   = faulted[P] ^ fire;
      end
    end else begin : g_inv
      always_comb begin
        lines_o      = faulted;
        lines_o[TGT] = ~faulted[TGT];
      end
    end
  endgenerate
endmodule

// File: rtl/ptc_top.sv
module ptc_top #(
  parameter int P = 4,
  parameter int G = 6,
  parameter logic [G*P-1:0] CTRL_MASK = 24'h8E9403,
  parameter logic [G*P-1:0] POL_MASK  = 24'h8E1003,
  parameter logic [G*8-1:0] TGT_IDX   = {8'd1, 8'd0, 8'd1, 8'd0, 8'd3, 8'd2},
  parameter int LINE_W = $clog2(P + 1),
  parameter int BND_W  = $clog2(G + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P-1:0]      data_in,
  input  logic              flt_en,
  input  logic [LINE_W-1:0] flt_line,
  input  logic [BND_W-1:0]  flt_bnd,
  output logic [P-1:0]      data_out,
  output logic              err
);
  import ptc_pkg::*;

  localparam logic CLOSE_INV =
    odd_plain_inverters(MAX_MASK_BITS'(CTRL_MASK), G, P);

  logic [P:0] lane [G+1];
  logic [P:0] flip [G+1];
  logic       open_par;
  logic       close_par;
  logic [P:0] tail;

  // Boundary fault decoders
  generate
    for (genvar b = 0; b <= G; b++) begin : g_bnd
      ptc_fault_dec #(.P(P), .LINE_W(LINE_W), .BND_W(BND_W), .BND(b)) u_dec (
        .en_i  (flt_en),
        .line_i(flt_line),
        .bnd_i (flt_bnd),
        .flip_o(flip[b])
      );
    end
  endgenerate

  // Opening fold onto the check line
  ptc_parity_fold #(.P(P)) u_open (.lines_i(data_in), .par_o(open_par));
  assign lane[0] = {open_par, data_in};

  // Gate cascade
  generate
    for (genvar k = 0; k < G; k++) begin : g_gate
      ptc_gate_stage #(
        .P   (P),
        .CTRL(CTRL_MASK[k*P +: P]),
        .POL (POL_MASK[k*P +: P]),
        .TGT (int'(TGT_IDX[k*TGT_FIELD_W +: TGT_FIELD_W]))
      ) u_stage (
        .lines_i(lane[k]),
        .flip_i (flip[k]),
        .lines_o(lane[k+1])
      );
    end
  endgenerate

  // Last boundary and closing fold
  assign tail = lane[G] ^ flip[G];
  ptc_parity_fold #(.P(P)) u_close (.lines_i(tail[P-1:0]), .par_o(close_par));

  logic [P-1:0] data_d;
  logic         err_d;

  always_comb begin
    data_d = tail[P-1:0];
    err_d  = tail[P] ^ close_par ^ CLOSE_INV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      err      <= 1'b0;
    end else begin
      data_out <= data_d;
      err      <= err_d;
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int P      = 4,
  parameter int G      = 6,
  parameter int LINE_W = 3,
  parameter int BND_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_en,
  input logic [LINE_W-1:0] flt_line,
  input logic [BND_W-1:0]  flt_bnd,
  input logic [P-1:0]      data_out,
  input logic              err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (data_out == '0 && err == 1'b0));

  assert_clean_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |=> !err);

  assert_data_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && int'(flt_line) < P && int'(flt_bnd) <= G) |=> err);

  assert_check_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && int'(flt_line) == P && int'(flt_bnd) <= G) |=> err);
endmodule

bind ptc_top ptc_checker #(.P(P), .G(G), .LINE_W(LINE_W), .BND_W(BND_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flt_en  (flt_en),
  .flt_line(flt_line),
  .flt_bnd (flt_bnd),
  .data_out(data_out),
  .err     (err)
);

// File: tb/ptc_top_test.sv
module ptc_top_test;
  localparam int P = 4;
  localparam int G = 6;

  logic       clk;
  logic       rst_n;
  logic [3:0] data_in;
  logic       flt_en;
  logic [2:0] flt_line;
  logic [2:0] flt_bnd;
  logic [3:0] data_out;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ptc_top uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .flt_en(flt_en),
    .flt_line(flt_line), .flt_bnd(flt_bnd), .data_out(data_out), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Default cascade written out gate by gate
  function automatic logic [3:0] ref_cascade(input logic [3:0] d);
    logic [3:0] v;
    v = d;
    v[2] = v[2] ^ (v[0] & v[1]);
    v[3] = ~v[3];
    v[0] = v[0] ^ ~v[2];
    v[1] = v[1] ^ (v[0] & ~v[3]);
    v[0] = v[0] ^ (v[1] & v[2] & v[3]);
    v[1] = v[1] ^ v[3];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic en, input logic [2:0] ln,
                       input logic [2:0] bd);
    @(negedge clk);
    data_in  = d;
    flt_en   = en;
    flt_line = ln;
    flt_bnd  = bd;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 4'h0, 4'h1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] exp;
    void'($urandom(32'd4711));
    rst_n = 1'b0; data_in = 4'hF; flt_en = 1'b1; flt_line = 3'd0; flt_bnd = 3'd0;
    repeat (3) @(negedge clk);
    check(data_out == 4'h0, "R1 data", data_out, 4'h0);
    check(err == 1'b0, "R1 err", {3'b0, err}, 4'h0);
    flt_en = 1'b0;
    rst_n  = 1'b1;
    @(negedge clk);
    check(err == 1'b0, "R1 after release", {3'b0, err}, 4'h0);

    // Exhaustive sweep: every vector, fault-free and every line/boundary
    for (int v = 0; v < 16; v++) begin
      apply(4'(v), 1'b0, 3'd0, 3'd0);
      exp = ref_cascade(4'(v));
      check(data_out == exp, "R2 data", data_out, exp);
      check(err == 1'b0, "R3 R7 clean flag", {3'b0, err}, 4'h0);
      for (int ln = 0; ln <= P; ln++) begin
        for (int bd = 0; bd <= G; bd++) begin
          apply(4'(v), 1'b1, 3'(ln), 3'(bd));
          if (ln < P) begin
            check(err == 1'b1, "R4 data-line fault", {3'b0, err}, 4'h1);
            if (bd == G) begin
              exp = ref_cascade(4'(v)) ^ (4'b1 << ln);
              check(data_out == exp, "R6 last boundary", data_out, exp);
            end
          end else begin
            check(err == 1'b1, "R5 check-line fault", {3'b0, err}, 4'h1);
            exp = ref_cascade(4'(v));
            check(data_out == exp, "R5 data untouched", data_out, exp);
          end
        end
      end
    end

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [3:0] d;
      logic       en;
      logic [2:0] ln, bd;
      d  = 4'($urandom % 16);
      en = 1'($urandom % 2);
      ln = 3'($urandom % (P + 1));
      bd = 3'($urandom % (G + 1));
      apply(d, en, ln, bd);
      if (!en) begin
        exp = ref_cascade(d);
        check(data_out == exp, "R8 disabled fault data", data_out, exp);
        check(err == 1'b0, "R8 disabled fault flag", {3'b0, err}, 4'h0);
      end else begin
        check(err == 1'b1, "R4 R5 random fault", {3'b0, err}, 4'h1);
        if (int'(ln) == P) begin
          exp = ref_cascade(d);
          check(data_out == exp, "R5 random data", data_out, exp);
        end else if (int'(bd) == G) begin
          exp = ref_cascade(d) ^ (4'b1 << ln);
          check(data_out == exp, "R6 random", data_out, exp);
        end
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule